// File: doc/BRIEF.md
# Programmable Polyphase Line Resampler

The block rescales a single line of 8-bit samples by a programmable ratio, from a quarter of the input rate up to four times the input rate. Software fills a 32-entry bank of signed Q8 coefficients. For each line, a controller loads the line configuration: filter shape, step, start phase, start offset, input length and output length. The controller then streams the input samples in. The block stores the whole line, then produces one filtered output sample per clock.

A fixed-point position accumulator with 8 fractional bits tracks where each output falls on the input line. Its integer part picks the centre input sample. The top fraction bits pick the filter phase. Two filter shapes share the one coefficient bank, and a mode pin selects between them: eight phases of four taps, or four phases of seven taps. Taps that fall outside the line repeat the nearest end sample. Each sum is rounded and clipped to the 8-bit range. Coefficient writes go to a staging copy. That copy is taken into use only when a new line begins.

Control is a three-state machine. In IDLE it waits for `line_go`; the transition IDLE→FILL latches the configuration and takes the coefficient snapshot. FILL stores the samples offered on `in_valid`; FILL→EMIT happens on the last sample of the line. EMIT issues one result per cycle; EMIT→IDLE happens with the last result.

Top module: `rs_resampler`

## Requirements
- R1: After reset `out_valid` is low. Samples offered on `in_valid` while no line has been started are neither stored nor answered with output.
- R2: After the last input sample of a line, exactly `cfg_out_len` results appear on consecutive cycles, and `out_valid` is low otherwise.
- R3: Output j sits at Q8 position P = `cfg_offset`*256 + `cfg_phase` + j*`cfg_step`. The integer part P>>8 is the centre sample index c.
- R4: With `cfg_mode`=0 (eight phases × four taps), the phase is P[7:5]. Tap k (0..3) multiplies coefficient entry phase*4+k by input sample c-1+k.
- R5: With `cfg_mode`=1 (four phases × seven taps), the phase is P[7:6]. Tap k (0..6) multiplies entry phase*8+k by sample c-3+k, and entries 7, 15, 23 and 31 never contribute.
- R6: A tap index below 0 reads sample 0, and a tap index beyond the last sample reads the last sample.
- R7: Each result is (sum + 128) shifted arithmetically right by 8. A negative value becomes 0, and a value above 255 becomes 255.
- R8: A coefficient written while a line is in FILL or EMIT has no effect on that line. It is used from the next `line_go` onward.
- R9: A `line_go` pulse while a line is in FILL or EMIT is ignored, together with the configuration offered with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 5 | Coefficient entry index |
| cw_data | input | 10 | Signed Q8 coefficient, -256..256 |
| line_go | input | 1 | Start a line (accepted only in IDLE) |
| cfg_mode | input | 1 | 0: eight phases of four taps, 1: four phases of seven taps |
| cfg_step | input | STEP_W | Unsigned Q8 input increment per output |
| cfg_phase | input | 8 | Fractional start position |
| cfg_offset | input | LEN_W | Integer start position |
| cfg_in_len | input | LEN_W | Input samples in the line (at least 1) |
| cfg_out_len | input | LEN_W | Output samples to produce (at least 1) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 8 | Output sample |

## Verification
The hardest case to provoke from the ports is a coefficient write or a second `line_go` that lands while a line is still in progress. Either event must leave the running line untouched. The stimulus reaches this case by issuing the write, or the altered start request, on the same cycles as samples 1 and 2 of a long line. The expected outputs come from the snapshot taken at the start of that line. The following line is then run unchanged, and it must show the rewritten entry. The clamping at both ends is reached by running a 4x upscale with a zero offset, and a 1/3 downscale whose last seven-tap window runs past the final sample.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int SAMP_W   = 8;
    localparam int COEF_W   = 10;
    localparam int N_COEF   = 32;
    localparam int FRAC_W   = 8;
    localparam int MAX_TAPS = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2
    } rs_state_e;

    typedef enum logic {
        MODE_P8T4 = 1'b0,
        MODE_P4T7 = 1'b1
    } rs_mode_e;
endpackage

// File: rtl/rs_coef_bank.sv
module rs_coef_bank
    import rs_pkg::*;
#(
    parameter int NC = N_COEF,
    parameter int CW = COEF_W,
    localparam int AW = $clog2(NC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CW-1:0]          wr_data,
    input  logic                   take,
    output logic [NC-1:0][CW-1:0]  act_tbl
);
    logic [NC-1:0][CW-1:0] stg_tbl;

    // staging copy: written at any time by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_tbl <= '0;
        end else begin
            for (int i = 0; i < NC; i++) begin
                if (wr_en && wr_addr == AW'(i)) begin
                    stg_tbl[i] <= wr_data;
                end
            end
        end
    end

    // active copy: refreshed only when a line is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_tbl <= '0;
        end else if (take) begin
            act_tbl <= stg_tbl;
        end
    end
endmodule

// File: rtl/rs_line_buf.sv
module rs_line_buf
    import rs_pkg::*;
#(
    parameter int DEPTH = 1280,
    parameter int LW    = 11,
    parameter int IW    = 14,
    parameter int NT    = MAX_TAPS,
    localparam int SW   = IW + 2
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [LW-1:0]              wr_addr,
    input  logic [SAMP_W-1:0]          wr_data,
    input  logic [LW-1:0]              len,
    input  logic [IW-1:0]              center,
    input  logic                       wide,
    output logic [NT-1:0][SAMP_W-1:0]  taps
);
    logic [SAMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    logic signed [SW-1:0] base_idx;
    logic signed [SW-1:0] last_idx;

    always_comb begin
        base_idx = $signed({2'b00, center}) - (wide ? SW'(3) : SW'(1));
        last_idx = $signed(SW'(len)) - SW'(1);
    end

    for (genvar k = 0; k < NT; k++) begin : g_tap
        logic signed [SW-1:0] idx;
        logic [LW-1:0]        addr;
        always_comb begin
            idx = base_idx + SW'(k);
            if (idx < 0) begin
                addr = '0;
            end else if (idx > last_idx) begin
                addr = last_idx[LW-1:0];
            end else begin
                addr = idx[LW-1:0];
            end
            taps[k] = mem[addr];
        end
    end
endmodule

// File: rtl/rs_filter_mac.sv
module rs_filter_mac
    import rs_pkg::*;
#(
    parameter int NC = N_COEF,
    parameter int CW = COEF_W,
    parameter int NT = MAX_TAPS,
    localparam int AW    = $clog2(NC),
    localparam int PW    = CW + SAMP_W + 1,
    localparam int ACC_W = PW + 3
) (
    input  logic [NC-1:0][CW-1:0]      act_tbl,
    input  logic                       wide,
    input  logic [2:0]                 phase,
    input  logic [NT-1:0][SAMP_W-1:0]  taps,
    output logic [SAMP_W-1:0]          result
);
    logic signed [PW-1:0] prod [NT];

    for (genvar k = 0; k < NT; k++) begin : g_prod
        logic [AW-1:0] cidx;
        logic          use_tap;
        if (k < 4) begin : g_both
            always_comb begin
                cidx    = wide ? {phase[2:1], 3'(k)} : {phase, 2'(k)};
                use_tap = 1'b1;
            end
        end else begin : g_wide
            always_comb begin
                cidx    = {phase[2:1], 3'(k)};
                use_tap = wide;
            end
        end
        always_comb begin
            if (use_tap) begin
                prod[k] = $signed(act_tbl[cidx]) * $signed({1'b0, taps[k]});
            end else begin
                prod[k] = '0;
            end
        end
    end

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rounded;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NT; k++) begin
            acc = acc + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
        end
        rounded = acc + ACC_W'(128);
        scaled  = rounded >>> FRAC_W;
        if (scaled < 0) begin
            result = '0;
        end else if (scaled > ACC_W'(255)) begin
            result = 8'hFF;
        end else begin
            result = scaled[SAMP_W-1:0];
        end
    end
endmodule

// File: rtl/rs_resampler.sv
module rs_resampler
    import rs_pkg::*;
#(
    parameter int MAX_LEN = 1280,
    parameter int STEP_W  = 11,
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int POS_INT_W = LEN_W + 3,
    localparam int POS_W     = POS_INT_W + FRAC_W,
    localparam int CA_W      = $clog2(N_COEF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cw_en,
    input  logic [CA_W-1:0]    cw_addr,
    input  logic [COEF_W-1:0]  cw_data,
    input  logic               line_go,
    input  logic               cfg_mode,
    input  logic [STEP_W-1:0]  cfg_step,
    input  logic [FRAC_W-1:0]  cfg_phase,
    input  logic [LEN_W-1:0]   cfg_offset,
    input  logic [LEN_W-1:0]   cfg_in_len,
    input  logic [LEN_W-1:0]   cfg_out_len,
    input  logic               in_valid,
    input  logic [SAMP_W-1:0]  in_data,
    output logic               out_valid,
    output logic [SAMP_W-1:0]  out_data
);
    rs_state_e                 state, state_nx;
    rs_mode_e                  cur_mode;
    logic [STEP_W-1:0]         cur_step;
    logic [LEN_W-1:0]          cur_in_len;
    logic [LEN_W-1:0]          cur_out_len;
    logic [POS_W-1:0]          pos;
    logic [LEN_W-1:0]          wr_idx;
    logic [LEN_W-1:0]          out_idx;
    logic                      go_ok;
    logic                      fill_last;
    logic                      emit_last;
    logic [N_COEF-1:0][COEF_W-1:0]       act_tbl;
    logic [MAX_TAPS-1:0][SAMP_W-1:0]     taps;
    logic [SAMP_W-1:0]         mac_res;
    logic                      wide;

    assign go_ok     = (state == ST_IDLE) && line_go;
    assign fill_last = in_valid && (wr_idx == cur_in_len - LEN_W'(1));
    assign emit_last = (out_idx == cur_out_len - LEN_W'(1));
    assign wide      = (cur_mode == MODE_P4T7);

    rs_coef_bank #(.NC(N_COEF), .CW(COEF_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_data (cw_data),
        .take    (go_ok),
        .act_tbl (act_tbl)
    );

    rs_line_buf #(.DEPTH(MAX_LEN), .LW(LEN_W), .IW(POS_INT_W), .NT(MAX_TAPS)) u_line (
        .clk     (clk),
        .wr_en   ((state == ST_FILL) && in_valid),
        .wr_addr (wr_idx),
        .wr_data (in_data),
        .len     (cur_in_len),
        .center  (pos[POS_W-1:FRAC_W]),
        .wide    (wide),
        .taps    (taps)
    );

    rs_filter_mac #(.NC(N_COEF), .CW(COEF_W), .NT(MAX_TAPS)) u_mac (
        .act_tbl (act_tbl),
        .wide    (wide),
        .phase   (pos[FRAC_W-1:FRAC_W-3]),
        .taps    (taps),
        .result  (mac_res)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (line_go)   state_nx = ST_FILL;
            ST_FILL: if (fill_last) state_nx = ST_EMIT;
            ST_EMIT: if (emit_last) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // configuration, counters and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode    <= MODE_P8T4;
            cur_step    <= '0;
            cur_in_len  <= '0;
            cur_out_len <= '0;
            pos         <= '0;
            wr_idx      <= '0;
            out_idx     <= '0;
            out_valid   <= 1'b0;
            out_data    <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (line_go) begin
                        cur_mode    <= rs_mode_e'(cfg_mode);
                        cur_step    <= cfg_step;
                        cur_in_len  <= cfg_in_len;
                        cur_out_len <= cfg_out_len;
                        pos         <= {POS_INT_W'(cfg_offset), cfg_phase};
                        wr_idx      <= '0;
                        out_idx     <= '0;
                    end
                end
                ST_FILL: begin
                    if (in_valid) begin
                        wr_idx <= wr_idx + LEN_W'(1);
                    end
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    out_data  <= mac_res;
                    pos       <= pos + POS_W'(cur_step);
                    out_idx   <= out_idx + LEN_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rs_resampler_chk.sv
module rs_resampler_chk
    import rs_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int POS_W  = 22,
    parameter int STEP_W = 11
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          line_go,
    input rs_state_e                     state,
    input logic                          out_valid,
    input logic [POS_W-1:0]              pos,
    input logic [STEP_W-1:0]             cur_step,
    input logic [LEN_W-1:0]              cur_out_len,
    input logic [N_COEF-1:0][COEF_W-1:0] act_tbl
);
    logic [LEN_W-1:0] emit_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_cnt <= '0;
        end else if (state == ST_IDLE && line_go) begin
            emit_cnt <= '0;
        end else if (out_valid) begin
            emit_cnt <= emit_cnt + LEN_W'(1);
        end
    end

    // R2: results only follow an EMIT cycle
    p_emit_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state) == ST_EMIT);

    // R2: never more results than requested
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> emit_cnt < cur_out_len);

    // R3: position advances by the step each emitted sample
    p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && $past(state) == ST_EMIT)
            |-> pos == $past(pos) + POS_W'($past(cur_step)));

    // R8: active coefficients frozen while a line runs
    p_coef_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(act_tbl));

    // R9: configuration untouched by a start request while busy
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(cur_out_len) && $stable(cur_step)));
endmodule

bind rs_resampler rs_resampler_chk #(
    .LEN_W  (LEN_W),
    .POS_W  (POS_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_go     (line_go),
    .state       (state),
    .out_valid   (out_valid),
    .pos         (pos),
    .cur_step    (cur_step),
    .cur_out_len (cur_out_len),
    .act_tbl     (act_tbl)
);

// File: tb/rs_resampler_tb.sv
module rs_resampler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 11;
    localparam int STEP_W     = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cw_en = 1'b0;
    logic [4:0]        cw_addr = '0;
    logic [9:0]        cw_data = '0;
    logic              line_go = 1'b0;
    logic              cfg_mode = 1'b0;
    logic [STEP_W-1:0] cfg_step = '0;
    logic [7:0]        cfg_phase = '0;
    logic [LEN_W-1:0]  cfg_offset = '0;
    logic [LEN_W-1:0]  cfg_in_len = '0;
    logic [LEN_W-1:0]  cfg_out_len = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              out_valid;
    logic [7:0]        out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_resampler u_dut (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
        .line_go(line_go), .cfg_mode(cfg_mode), .cfg_step(cfg_step), .cfg_phase(cfg_phase),
        .cfg_offset(cfg_offset), .cfg_in_len(cfg_in_len), .cfg_out_len(cfg_out_len),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    int    stg [32];
    int    act_m [32];
    int    samp [64];
    int    exp_q [$];
    string tag_q [$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_out(int mode, int step, int ph, int off, int inlen, int j);
        int pos, c, phs, ntap, back, acc, idx, r;
        pos  = off * 256 + ph + j * step;
        c    = pos >> 8;
        phs  = (mode == 1) ? ((pos & 255) >> 6) : ((pos & 255) >> 5);
        ntap = (mode == 1) ? 7 : 4;
        back = (mode == 1) ? 3 : 1;
        acc  = 0;
        for (int k = 0; k < ntap; k++) begin
            idx = c - back + k;
            if (idx < 0) idx = 0;
            if (idx > inlen - 1) idx = inlen - 1;
            acc += act_m[(mode == 1) ? phs * 8 + k : phs * 4 + k] * samp[idx];
        end
        r = (acc + 128) >>> 8;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic write_coef(int a, int v);
        @(negedge clk);
        cw_en = 1'b1; cw_addr = a[4:0]; cw_data = v[9:0]; stg[a] = v;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic run_line(int mode, int step, int ph, int off, int inlen, int outlen,
                            string tag, int rw_addr, int rw_val, bit bump);
        for (int i = 0; i < 32; i++) act_m[i] = stg[i];
        for (int j = 0; j < outlen; j++) begin
            exp_q.push_back(ref_out(mode, step, ph, off, inlen, j));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        line_go = 1'b1; cfg_mode = mode[0]; cfg_step = STEP_W'(step);
        cfg_phase = ph[7:0]; cfg_offset = LEN_W'(off);
        cfg_in_len = LEN_W'(inlen); cfg_out_len = LEN_W'(outlen);
        @(negedge clk);
        line_go = 1'b0;
        for (int i = 0; i < inlen; i++) begin
            in_valid = 1'b1; in_data = samp[i][7:0];
            if (i == 2 && rw_addr >= 0) begin
                cw_en = 1'b1; cw_addr = rw_addr[4:0]; cw_data = rw_val[9:0]; stg[rw_addr] = rw_val;
            end else begin
                cw_en = 1'b0;
            end
            if (i == 1 && bump) begin
                line_go = 1'b1; cfg_out_len = LEN_W'(outlen + 3);
                cfg_mode = ~mode[0]; cfg_step = STEP_W'(step + 40);
            end else begin
                line_go = 1'b0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0; cw_en = 1'b0; line_go = 1'b0;
        repeat (outlen + 4) @(negedge clk);
        chk(exp_q.size() == 0, {"R2 drained ", tag}, exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: compare each result with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected output", int'(out_data), -1);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'(out_data) == e, t, int'(out_data), e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) stg[i] = 0;
        for (int i = 0; i < 64; i++) samp[i] = (i * 53 + 17) % 256;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

        // R1: stray samples while idle
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'hEE;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle samples ignored", int'(out_valid), 0);

        // R4 / R3: eight-phase mode, 2x upscale
        for (int a = 0; a < 32; a++) write_coef(a, ((a * 37 + 11) % 97) - 30);
        write_coef(0, 0);  write_coef(1, 256); write_coef(2, 0);   write_coef(3, 0);
        write_coef(16, -32); write_coef(17, 160); write_coef(18, 160); write_coef(19, -32);
        run_line(0, 128, 0, 0, 8, 16, "R4 p8t4 2x", -1, 0, 1'b0);

        // R3: offset and start phase with an odd step
        run_line(0, 300, 8'hA0, 5, 20, 12, "R3 offset/phase", -1, 0, 1'b0);

        // R5: seven-tap mode, unused entries loaded with a large value
        for (int a = 0; a < 32; a++) write_coef(a, ((a * 53 + 7) % 89) - 20);
        for (int p = 0; p < 4; p++) write_coef(p * 8 + 7, 255);
        run_line(1, 768, 8'h40, 0, 30, 10, "R5 p4t7 1/3x", -1, 0, 1'b0);

        // R6: left clamp under 4x upscale in seven-tap mode
        run_line(1, 64, 0, 0, 6, 24, "R6 edge clamp", -1, 0, 1'b0);

        // R7: saturation high, saturation low, rounding
        for (int p = 0; p < 8; p++) begin
            write_coef(p*4, 0); write_coef(p*4+1, 256); write_coef(p*4+2, 256); write_coef(p*4+3, 0);
        end
        run_line(0, 256, 0, 0, 10, 10, "R7 sat high", -1, 0, 1'b0);
        for (int p = 0; p < 8; p++) begin
            write_coef(p*4+1, -256); write_coef(p*4+2, 0);
        end
        run_line(0, 256, 0, 0, 10, 10, "R7 sat low", -1, 0, 1'b0);
        for (int p = 0; p < 8; p++) write_coef(p*4+1, 128);
        run_line(0, 256, 0, 0, 10, 10, "R7 rounding", -1, 0, 1'b0);

        // R8: rewrite during fill, then next line
        run_line(0, 256, 0, 0, 10, 10, "R8 old coef kept", 1, 256, 1'b0);
        run_line(0, 256, 0, 0, 10, 10, "R8 new coef used", -1, 0, 1'b0);

        // R9: start request while busy
        run_line(0, 200, 8'h10, 2, 24, 9, "R9 busy go ignored", -1, 0, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule